// File: doc/BRIEF.md
# JTAG-to-bus-master command bridge

The bridge lets a debug host drive a 32-bit memory-mapped bus master through a JTAG user data register. In the TCK domain it has a 48-bit scan register that responds to three strobes: capture, shift and update. Each scan moves a command word in from TDI. In the same scan, the response to the previous command leaves on TDO. So every response arrives one scan late, and the host polls with a NOP command to collect the last one.

An accepted command crosses into the system clock domain through a toggle handshake. There a small controller carries it out. Reads and writes are single-byte accesses with byte-lane steering. A ping returns a fixed byte. Two commands set and clear a sticky reset output for a target. Each result crosses back to the TCK domain and is loaded at the next capture. A command that arrives while an earlier one is still being carried out is dropped, and the host sends it again.

Top module: `jtag_bus_bridge`

## Requirements
- R1: The scan word is {opcode[47:40], address[39:8], byte[7:0]}. It enters on `tdi` least significant bit first. A capture loads the response word, `tdo` shows bit 0 of the scan register, and each shift moves `tdi` into bit 47. An update issues the command, and its response appears in the capture of the following scan.
- R2: Response word layout: bit 37 is the valid flag, bits [23:16] are the result byte, bits [7:0] repeat the opcode of the last completed command, and all other bits are zero. Until the first command completes, a capture returns all zeros.
- R3: Opcode 0x30 (ping) completes with result byte 0xA5 and makes no bus access.
- R4: Opcode 0x20 (byte write) makes exactly one bus access. It has `bus_we`=1, `bus_adr` equal to the full 32-bit address, `bus_sel` = 1 << address[1:0], and `bus_wdat` = byte << (8*address[1:0]). The result byte is 0x00.
- R5: Opcode 0x21 (byte read) makes exactly one bus access with `bus_we`=0 and the same address and select rule as R4. The result byte is bits [8*address[1:0]+7 : 8*address[1:0]] of `bus_rdat` at the acknowledge.
- R6: `bus_cyc` and `bus_stb` rise together and stay high, with address, select, data and direction held stable, until the cycle in which `bus_ack` is sampled high. Both fall on the next clock.
- R7: Opcode 0x10 sets `tgt_rst` high and opcode 0x11 sets it low. The level holds between those commands. Both complete with result byte 0x00 and no bus access.
- R8: Opcode 0x00 (NOP) makes no bus access and completes with result byte 0x00 and opcode 0x00.
- R9: An update that arrives while an earlier command has not yet completed is ignored. It makes no bus access, and the next response still reports the earlier command.
- R10: Asserting either `tck_rst` or `rst` clears the scan register (`tdo` reads 0), the pending request, the valid flag and `tgt_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, TCK domain |
| tdi | input | 1 | Serial data in |
| cap_en | input | 1 | Capture strobe, sampled on tck |
| shift_en | input | 1 | Shift strobe, sampled on tck |
| upd_en | input | 1 | Update strobe, sampled on tck |
| tdo | output | 1 | Serial data out (scan register bit 0) |
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| bus_adr | output | 32 | Bus address |
| bus_wdat | output | 32 | Bus write data |
| bus_sel | output | 4 | Byte-lane select |
| bus_we | output | 1 | Write enable |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus strobe |
| bus_rdat | input | 32 | Bus read data |
| bus_ack | input | 1 | Bus acknowledge |
| tgt_rst | output | 1 | Sticky reset output for a target |

## Verification
The bench checks the one-scan response pipeline, so a bridge that returned the current command's own result, or a stale one, would fail every response check. It targets lane steering at all four address offsets with random slave latencies; mis-shifted select or data would corrupt the shadow memory that later reads are compared against. It sends a write while a read is held unacknowledged; a bridge that accepted that command would show an extra bus access, and the echoed opcode would change. It applies each domain's reset alone, and checks that a stale scan register, a surviving valid flag or a stuck target reset would show up at `tdo` and in the next capture.

// File: rtl/jbb_pkg.sv
package jbb_pkg;
  localparam int OP_W    = 8;
  localparam int ADR_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int CMD_W   = OP_W + ADR_W + BYTE_W;
  localparam int OP_LSB  = ADR_W + BYTE_W;
  localparam int ADR_LSB = BYTE_W;
  localparam int VALID_BIT = 37;
  localparam int RDAT_LSB  = 16;

  localparam logic [OP_W-1:0] OP_NOP     = 8'h00;
  localparam logic [OP_W-1:0] OP_RST_SET = 8'h10;
  localparam logic [OP_W-1:0] OP_RST_CLR = 8'h11;
  localparam logic [OP_W-1:0] OP_WR      = 8'h20;
  localparam logic [OP_W-1:0] OP_RD      = 8'h21;
  localparam logic [OP_W-1:0] OP_PING    = 8'h30;
  localparam logic [BYTE_W-1:0] PING_BYTE = 8'hA5;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [BYTE_W-1:0] data;
  } rsp_t;

  function automatic logic [CMD_W-1:0] pack_resp(input logic v, input rsp_t r);
    logic [CMD_W-1:0] w;
    w = '0;
    w[VALID_BIT] = v;
    w[RDAT_LSB +: BYTE_W] = r.data;
    w[0 +: OP_W] = r.op;
    return w;
  endfunction
endpackage

// File: rtl/jbb_sync.sv
module jbb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '0;
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/jbb_scan.sv
module jbb_scan
  import jbb_pkg::*;
(
  input  logic             tck,
  input  logic             rst_t,
  input  logic             tdi,
  input  logic             cap_en,
  input  logic             shift_en,
  input  logic             upd_en,
  output logic             tdo,
  output logic             req_tgl,
  output logic [CMD_W-1:0] cmd_q,
  input  logic             ack_s,
  input  rsp_t             rsp_in
);
  logic [CMD_W-1:0] sreg;
  logic             busy;
  logic             valid;
  logic             ack_d;
  rsp_t             rsp_q;

  always_ff @(posedge tck) begin
    if (rst_t) begin
      sreg    <= '0;
      busy    <= 1'b0;
      valid   <= 1'b0;
      ack_d   <= 1'b0;
      req_tgl <= 1'b0;
      cmd_q   <= '0;
      rsp_q   <= '0;
    end else begin
      ack_d <= ack_s;
      if (ack_s != ack_d) begin
        busy  <= 1'b0;
        valid <= 1'b1;
        rsp_q <= rsp_in;
      end
      if (cap_en)
        sreg <= pack_resp(valid, rsp_q);
      else if (shift_en)
        sreg <= {tdi, sreg[CMD_W-1:1]};
      if (upd_en && !busy) begin
        cmd_q   <= sreg;
        req_tgl <= ~req_tgl;
        busy    <= 1'b1;
      end
    end
  end

  assign tdo = sreg[0];

  // R9
  busy_hold_chk: assert property (@(posedge tck) disable iff (rst_t)
    (busy && upd_en) |=> $stable(cmd_q));
endmodule

// File: rtl/jbb_ctrl.sv
module jbb_ctrl
  import jbb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_c,
  input  logic             req_s,
  input  logic [CMD_W-1:0] cmd,
  output logic             ack_tgl,
  output rsp_t             rsp,
  output logic [ADR_W-1:0] bus_adr,
  output logic [DW-1:0]    bus_wdat,
  output logic [DW/8-1:0]  bus_sel,
  output logic             bus_we,
  output logic             bus_cyc,
  output logic             bus_stb,
  input  logic [DW-1:0]    bus_rdat,
  input  logic             bus_ack,
  output logic             tgt_rst
);
  localparam int LANES  = DW / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic {ST_IDLE, ST_BUS} st_e;
  st_e st;

  logic              req_d;
  logic [OP_W-1:0]   c_op;
  logic [ADR_W-1:0]  c_adr;
  logic [BYTE_W-1:0] c_dat;
  logic [LANE_W-1:0] c_lane;
  logic [LANE_W-1:0] act_lane;
  logic [DW-1:0]     rd_shift;

  assign c_op   = cmd[OP_LSB +: OP_W];
  assign c_adr  = cmd[ADR_LSB +: ADR_W];
  assign c_dat  = cmd[0 +: BYTE_W];
  assign c_lane = c_adr[LANE_W-1:0];
  assign act_lane = bus_adr[LANE_W-1:0];
  assign rd_shift = bus_rdat >> {act_lane, 3'b000};

  always_ff @(posedge clk) begin
    if (rst_c) begin
      st       <= ST_IDLE;
      req_d    <= 1'b0;
      ack_tgl  <= 1'b0;
      rsp      <= '0;
      bus_adr  <= '0;
      bus_wdat <= '0;
      bus_sel  <= '0;
      bus_we   <= 1'b0;
      bus_cyc  <= 1'b0;
      bus_stb  <= 1'b0;
      tgt_rst  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          req_d <= req_s;
          if (req_s != req_d) begin
            rsp.op   <= c_op;
            rsp.data <= '0;
            case (c_op)
              OP_WR, OP_RD: begin
                bus_adr  <= c_adr;
                bus_sel  <= LANES'(1) << c_lane;
                bus_wdat <= {{(DW-BYTE_W){1'b0}}, c_dat} << {c_lane, 3'b000};
                bus_we   <= (c_op == OP_WR);
                bus_cyc  <= 1'b1;
                bus_stb  <= 1'b1;
                st       <= ST_BUS;
              end
              OP_PING: begin
                rsp.data <= PING_BYTE;
                ack_tgl  <= ~ack_tgl;
              end
              OP_RST_SET: begin
                tgt_rst <= 1'b1;
                ack_tgl <= ~ack_tgl;
              end
              OP_RST_CLR: begin
                tgt_rst <= 1'b0;
                ack_tgl <= ~ack_tgl;
              end
              default: ack_tgl <= ~ack_tgl;
            endcase
          end
        end
        ST_BUS: begin
          if (bus_ack) begin
            bus_cyc <= 1'b0;
            bus_stb <= 1'b0;
            if (!bus_we) rsp.data <= rd_shift[BYTE_W-1:0];
            ack_tgl <= ~ack_tgl;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  cyc_hold_chk: assert property (@(posedge clk) disable iff (rst_c)
    (bus_cyc && !bus_ack) |=> (bus_cyc && bus_stb));
  // R6
  cyc_drop_chk: assert property (@(posedge clk) disable iff (rst_c)
    (bus_cyc && bus_ack) |=> (!bus_cyc && !bus_stb));
  // R6
  adr_stable_chk: assert property (@(posedge clk) disable iff (rst_c)
    (bus_cyc && !bus_ack) |=> ($stable(bus_adr) && $stable(bus_sel) && $stable(bus_we)));
  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst_c)
    bus_cyc |-> ($countones(bus_sel) == 1));
endmodule

// File: rtl/jtag_bus_bridge.sv
module jtag_bus_bridge
  import jbb_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             tck,
  input  logic             tck_rst,
  input  logic             tdi,
  input  logic             cap_en,
  input  logic             shift_en,
  input  logic             upd_en,
  output logic             tdo,
  input  logic             clk,
  input  logic             rst,
  output logic [ADR_W-1:0] bus_adr,
  output logic [DW-1:0]    bus_wdat,
  output logic [DW/8-1:0]  bus_sel,
  output logic             bus_we,
  output logic             bus_cyc,
  output logic             bus_stb,
  input  logic [DW-1:0]    bus_rdat,
  input  logic             bus_ack,
  output logic             tgt_rst
);
  logic             rst_sys_t, rst_tck_c, rst_t, rst_c;
  logic             req_tgl, req_s, ack_tgl, ack_s;
  logic [CMD_W-1:0] cmd_q;
  rsp_t             rsp;

  jbb_sync #(.STAGES(SYNC_STAGES)) u_rst_to_tck (
    .clk(tck), .rst(1'b0), .d(rst), .q(rst_sys_t));
  jbb_sync #(.STAGES(SYNC_STAGES)) u_rst_to_clk (
    .clk(clk), .rst(1'b0), .d(tck_rst), .q(rst_tck_c));

  assign rst_t = tck_rst | rst_sys_t;
  assign rst_c = rst | rst_tck_c;

  jbb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst_c), .d(req_tgl), .q(req_s));
  jbb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(tck), .rst(rst_t), .d(ack_tgl), .q(ack_s));

  jbb_scan u_scan (
    .tck(tck), .rst_t(rst_t), .tdi(tdi), .cap_en(cap_en), .shift_en(shift_en),
    .upd_en(upd_en), .tdo(tdo), .req_tgl(req_tgl), .cmd_q(cmd_q),
    .ack_s(ack_s), .rsp_in(rsp));

  jbb_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_c(rst_c), .req_s(req_s), .cmd(cmd_q), .ack_tgl(ack_tgl),
    .rsp(rsp), .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_rdat(bus_rdat),
    .bus_ack(bus_ack), .tgt_rst(tgt_rst));
endmodule

// File: tb/jtag_bus_bridge_bench.sv
`timescale 1ns/1ps
module jtag_bus_bridge_bench;
  logic tck = 0, clk = 0;
  logic tck_rst = 1, rst = 1;
  logic tdi = 0, cap_en = 0, shift_en = 0, upd_en = 0;
  logic tdo;
  logic [31:0] bus_adr, bus_wdat, bus_rdat;
  logic [3:0]  bus_sel;
  logic bus_we, bus_cyc, bus_stb, bus_ack, tgt_rst;

  always #2  clk = ~clk;
  always #10 tck = ~tck;

  jtag_bus_bridge u_jtag_bus_bridge (
    .tck(tck), .tck_rst(tck_rst), .tdi(tdi), .cap_en(cap_en), .shift_en(shift_en),
    .upd_en(upd_en), .tdo(tdo), .clk(clk), .rst(rst), .bus_adr(bus_adr),
    .bus_wdat(bus_wdat), .bus_sel(bus_sel), .bus_we(bus_we), .bus_cyc(bus_cyc),
    .bus_stb(bus_stb), .bus_rdat(bus_rdat), .bus_ack(bus_ack), .tgt_rst(tgt_rst));

  int n_tests = 0, n_fail = 0;
  logic [7:0] mem [64];
  logic [7:0] shadow [64];
  int acc_cnt = 0, lat = 0, wcnt = 0, prot_err = 0;
  logic hold = 0, ack_prev = 0;
  logic [31:0] l_adr, l_wdat;
  logic [3:0]  l_sel;
  logic        l_we;
  logic [47:0] prev_resp;
  logic        exp_tr;

  function automatic logic [47:0] resp(input logic v, input logic [7:0] d, input logic [7:0] op);
    logic [47:0] w;
    w = '0; w[37] = v; w[23:16] = d; w[7:0] = op;
    return w;
  endfunction

  function automatic logic [47:0] cmdw(input logic [7:0] op, input logic [31:0] a, input logic [7:0] d);
    return {op, a, d};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // bus slave: byte memory with programmable latency and hold
  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 0; bus_rdat <= 0; wcnt <= 0;
    end else if (bus_ack) begin
      bus_ack <= 0;
    end else if (bus_cyc && bus_stb && !hold) begin
      if (wcnt >= lat) begin
        wcnt <= 0;
        bus_ack <= 1;
        acc_cnt <= acc_cnt + 1;
        l_adr <= bus_adr; l_sel <= bus_sel; l_we <= bus_we; l_wdat <= bus_wdat;
        for (int b = 0; b < 4; b++)
          if (bus_we && bus_sel[b]) mem[{bus_adr[5:2], 2'(b)}] <= bus_wdat[8*b +: 8];
        bus_rdat <= {mem[{bus_adr[5:2], 2'd3}], mem[{bus_adr[5:2], 2'd2}],
                     mem[{bus_adr[5:2], 2'd1}], mem[{bus_adr[5:2], 2'd0}]};
      end else wcnt <= wcnt + 1;
    end
  end

  // R6 protocol monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_cyc !== bus_stb) prot_err++;
      if (ack_prev && bus_cyc) prot_err++;
    end
    ack_prev = bus_ack;
  end

  task automatic scan(input logic [47:0] tx, output logic [47:0] rx);
    @(negedge tck); cap_en = 1;
    @(negedge tck); cap_en = 0; shift_en = 1;
    for (int k = 0; k < 48; k++) begin
      tdi = tx[k]; rx[k] = tdo;
      @(negedge tck);
    end
    shift_en = 0; upd_en = 1;
    @(negedge tck); upd_en = 0;
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [31:0] a, input logic [7:0] d);
    logic [47:0] rx;
    int c0;
    logic [1:0] ln;
    ln = a[1:0];
    c0 = acc_cnt;
    scan(cmdw(op, a, d), rx);
    check("R1 R2 pipelined response", {16'h0, rx}, {16'h0, prev_resp});
    repeat (12) @(negedge tck);
    case (op)
      8'h20: begin
        check("R4 one write access", acc_cnt, c0 + 1);
        check("R4 we", l_we, 1);
        check("R4 address", l_adr, a);
        check("R4 select", l_sel, 4'b0001 << ln);
        check("R4 lane data", l_wdat, {24'h0, d} << (8 * ln));
        shadow[a[5:0]] = d;
        prev_resp = resp(1, 8'h00, op);
      end
      8'h21: begin
        check("R5 one read access", acc_cnt, c0 + 1);
        check("R5 we", l_we, 0);
        check("R5 address", l_adr, a);
        check("R5 select", l_sel, 4'b0001 << ln);
        prev_resp = resp(1, shadow[a[5:0]], op);
      end
      8'h30: begin
        check("R3 ping no access", acc_cnt, c0);
        prev_resp = resp(1, 8'hA5, op);
      end
      8'h10, 8'h11: begin
        exp_tr = (op == 8'h10);
        check("R7 no access", acc_cnt, c0);
        prev_resp = resp(1, 8'h00, op);
      end
      default: begin
        check("R8 nop no access", acc_cnt, c0);
        prev_resp = resp(1, 8'h00, op);
      end
    endcase
    check("R7 tgt_rst level", tgt_rst, exp_tr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] rx;
    int c0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 7 + 3); shadow[i] = 8'(i * 7 + 3);
    end
    prev_resp = '0; exp_tr = 0;
    repeat (10) @(negedge tck);
    tck_rst = 0; rst = 0;
    repeat (5) @(negedge tck);
    check("R10 reset tdo", tdo, 0);
    check("R10 reset tgt_rst", tgt_rst, 0);
    check("R6 reset idle bus", bus_cyc, 0);

    // directed: ping, all four lanes, 0x13 example
    run_cmd(8'h30, 32'h0, 8'h00);
    for (int ln = 0; ln < 4; ln++) begin
      run_cmd(8'h20, 32'h1234_5610 + ln, 8'h5A + 8'(ln));
      run_cmd(8'h21, 32'h1234_5610 + ln, 8'h00);
    end
    run_cmd(8'h20, 32'h0000_0013, 8'h5A);
    check("R4 example select", l_sel, 4'b1000);
    check("R4 example data", l_wdat, 32'h5A00_0000);
    run_cmd(8'h10, 32'h0, 8'h00);
    run_cmd(8'h00, 32'h0, 8'h00);
    run_cmd(8'h11, 32'h0, 8'h00);

    // R9: command during an unacknowledged read is dropped
    hold = 1; lat = 0;
    c0 = acc_cnt;
    scan(cmdw(8'h21, 32'h0000_0008, 8'h00), rx);
    check("R1 R2 response before held read", {16'h0, rx}, {16'h0, prev_resp});
    repeat (12) @(negedge tck);
    check("R6 cyc held without ack", bus_cyc, 1);
    scan(cmdw(8'h20, 32'h0000_0008, 8'h77), rx);
    check("R9 response still old", {16'h0, rx}, {16'h0, prev_resp});
    repeat (12) @(negedge tck);
    check("R9 no access while held", acc_cnt, c0);
    hold = 0;
    repeat (12) @(negedge tck);
    check("R9 single access after release", acc_cnt, c0 + 1);
    check("R9 access was the read", l_we, 0);
    prev_resp = resp(1, shadow[8], 8'h21);
    run_cmd(8'h00, 32'h0, 8'h00);
    run_cmd(8'h21, 32'h0000_0008, 8'h00);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [7:0] op;
      logic [31:0] a;
      case ($urandom % 6)
        0: op = 8'h00; 1: op = 8'h30; 2: op = 8'h20;
        3: op = 8'h21; 4: op = 8'h10; default: op = 8'h11;
      endcase
      a = {$urandom % 32'h0400_0000, 6'($urandom)};
      lat = $urandom % 4;
      run_cmd(op, a, 8'($urandom));
    end

    // R10: system reset alone
    run_cmd(8'h10, 32'h0, 8'h01);
    check("R10 tdo before reset", tdo, 1);
    rst = 1; repeat (4) @(negedge tck); rst = 0; repeat (4) @(negedge tck);
    check("R10 sys rst clears scan reg", tdo, 0);
    check("R10 sys rst clears tgt_rst", tgt_rst, 0);
    exp_tr = 0; prev_resp = '0;
    run_cmd(8'h00, 32'h0, 8'h00);
    // R10: TCK reset alone
    run_cmd(8'h10, 32'h0, 8'h01);
    tck_rst = 1; repeat (4) @(negedge tck); tck_rst = 0; repeat (4) @(negedge tck);
    check("R10 tck rst clears scan reg", tdo, 0);
    check("R10 tck rst clears tgt_rst", tgt_rst, 0);
    exp_tr = 0; prev_resp = '0;
    run_cmd(8'h30, 32'h0, 8'h00);
    run_cmd(8'h00, 32'h0, 8'h00);

    check("R6 protocol monitor errors", prot_err, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule